// File: doc/BRIEF.md
# Set-Associative Page Translation Cache

This block caches virtual-to-physical page translations for a 32-bit address space that uses 4 KB pages. It holds 64 entries as 16 sets of 4 ways. A lookup takes the virtual page number from the upper 20 address bits. The low 4 bits of that number pick a set and the upper 16 bits form the tag. The block compares the tag against all four ways of the chosen set.

The result is registered and appears one cycle after the request. On a hit the physical address is the stored 20-bit frame number with the request's 12-bit page offset appended unchanged. On a miss the requester asks an external page-table walker for the translation, and the walker returns it through the refill port. A refill goes first to a way that already holds the same tag, then to the lowest free way, and otherwise to the way named by a round-robin pointer kept for each set. A flush input drops every translation in one cycle.

Top module: `tlb_top`

## Requirements
- R1: While `rst` is high, `rsp_valid` stays low. After reset every entry is invalid, so any lookup misses.
- R2: Every cycle with `lkp_valid` high produces exactly one response on the next cycle. `rsp_valid` is high in that cycle, and exactly one of `rsp_hit` and `rsp_miss` is high. With no request, all three stay low.
- R3: The set index is `lkp_va[15:12]` and the tag is `lkp_va[31:16]`. For refills they are `fill_vpn[3:0]` and `fill_vpn[19:4]`. A lookup hits only when a valid way of the selected set holds the same tag.
- R4: On a hit, `rsp_pa` equals the stored frame number in bits 31:12 and `lkp_va[11:0]` in bits 11:0. On a miss, `rsp_pa` is zero.
- R5: A refill whose tag is not present in a set that has a free way writes the lowest-numbered free way. It leaves all other ways and the set's pointer untouched.
- R6: A refill whose tag is not present in a full set replaces the way named by that set's 2-bit pointer. The pointer then advances by one modulo 4. Pointers reset to way 0 and are independent per set.
- R7: A refill whose tag is already valid in the set overwrites that way's frame number. It evicts nothing and does not move the pointer, so a set never holds two valid copies of one tag.
- R8: A lookup and a refill to the same set in the same cycle are reported as a miss, and the refill is still written. A refill to a different set does not affect the lookup result.
- R9: `flush` invalidates all 64 entries at the next clock edge. A lookup in the flush cycle misses. A refill in the flush cycle is discarded. The replacement pointers keep their values.
- R10: All 64 entries can hold distinct translations at the same time, and each one then hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate every entry |
| lkp_valid | input | 1 | Lookup request |
| lkp_va | input | 32 | Virtual address to translate |
| fill_valid | input | 1 | Refill request from the walker |
| fill_vpn | input | 20 | Virtual page number being refilled |
| fill_ppn | input | 20 | Physical frame number being refilled |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | Translation absent, walk required |
| rsp_pa | output | 32 | Physical address on a hit, zero otherwise |

## Verification
The bench fills one set past capacity, so a design with a wrong or shared pointer evicts the wrong tag, and a later lookup then hits where a miss is due or the reverse. It refills a tag that is already present and then adds a new tag. A design that evicts on a duplicate, or advances the pointer on one, loses an unrelated translation. It issues lookups that collide with a refill or a flush in the same cycle. A design that forwards the refill or reads stale contents reports a hit there. A long random stream with few distinct tags per set also runs against a behavioural model to catch slips in offset handling and set selection.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int TLB_VA_W  = 32;
    localparam int TLB_OFF_W = 12;
    localparam int TLB_VPN_W = TLB_VA_W - TLB_OFF_W;
    localparam int TLB_PPN_W = 20;
    localparam int TLB_PA_W  = TLB_PPN_W + TLB_OFF_W;
    localparam int TLB_SET_W = 4;
    localparam int TLB_SETS  = 1 << TLB_SET_W;
    localparam int TLB_WAYS  = 4;
    localparam int TLB_WAY_W = $clog2(TLB_WAYS);
    localparam int TLB_TAG_W = TLB_VPN_W - TLB_SET_W;

    typedef logic [TLB_VPN_W-1:0] vpn_t;
    typedef logic [TLB_TAG_W-1:0] tag_t;
    typedef logic [TLB_PPN_W-1:0] ppn_t;
    typedef logic [TLB_SET_W-1:0] set_idx_t;
    typedef logic [TLB_WAY_W-1:0] way_idx_t;
    typedef logic [TLB_OFF_W-1:0] offset_t;

    typedef struct packed {
        logic vld;
        tag_t tag;
        ppn_t ppn;
    } tlb_ent_t;

    typedef tlb_ent_t [TLB_WAYS-1:0] tlb_row_t;

    typedef struct packed {
        logic     hit;
        way_idx_t way;
        ppn_t     ppn;
    } match_t;

    function automatic set_idx_t set_of(vpn_t v);
        return v[TLB_SET_W-1:0];
    endfunction

    function automatic tag_t tag_of(vpn_t v);
        return v[TLB_VPN_W-1:TLB_SET_W];
    endfunction

    // lowest-numbered invalid way; meaningful only when the row is not full
    function automatic way_idx_t first_free(tlb_row_t r);
        way_idx_t w = '0;
        for (int i = TLB_WAYS - 1; i >= 0; i--) begin
            if (!r[i].vld) w = way_idx_t'(i);
        end
        return w;
    endfunction

    function automatic logic row_full(tlb_row_t r);
        logic f = 1'b1;
        for (int i = 0; i < TLB_WAYS; i++) f = f & r[i].vld;
        return f;
    endfunction

endpackage

// File: rtl/tlb_tag_match.sv
module tlb_tag_match
    import tlb_pkg::*;
(
    input  tlb_row_t              row_i,
    input  tag_t                  tag_i,
    output logic [TLB_WAYS-1:0]   hit_vec_o,
    output match_t                res_o
);

    for (genvar w = 0; w < TLB_WAYS; w++) begin : g_cmp
        assign hit_vec_o[w] = row_i[w].vld && (row_i[w].tag == tag_i);
    end

    always_comb begin
        res_o = '0;
        for (int i = 0; i < TLB_WAYS; i++) begin
            if (hit_vec_o[i]) begin
                res_o.hit = 1'b1;
                res_o.way = way_idx_t'(i);
                res_o.ppn = row_i[i].ppn;
            end
        end
    end

endmodule

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     flush_i,
    input  logic     we_i,
    input  set_idx_t wset_i,
    input  way_idx_t wway_i,
    input  tlb_ent_t went_i,
    input  set_idx_t rset_a_i,
    input  set_idx_t rset_b_i,
    output tlb_row_t row_a_o,
    output tlb_row_t row_b_o
);

    tlb_row_t rows [TLB_SETS];

    for (genvar s = 0; s < TLB_SETS; s++) begin : g_set
        tlb_row_t row_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                row_q <= '0;
            end else if (flush_i) begin
                for (int w = 0; w < TLB_WAYS; w++) row_q[w].vld <= 1'b0;
            end else if (we_i && (wset_i == set_idx_t'(s))) begin
                row_q[wway_i] <= went_i;
            end
        end
        assign rows[s] = row_q;
    end

    assign row_a_o = rows[rset_a_i];
    assign row_b_o = rows[rset_b_i];

    logic any_vld;
    always_comb begin
        any_vld = 1'b0;
        for (int s = 0; s < TLB_SETS; s++)
            for (int w = 0; w < TLB_WAYS; w++)
                any_vld = any_vld | rows[s][w].vld;
    end

    // R9
    flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> !any_vld);

    // R1
    reset_empty_chk: assert property (@(posedge clk)
        rst |=> (rst || !any_vld));

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     fill_en_i,
    input  set_idx_t set_i,
    input  tlb_row_t row_i,
    input  match_t   dup_i,
    output way_idx_t way_o
);

    way_idx_t ptr_q [TLB_SETS];
    logic     full;
    way_idx_t free_way;

    assign full     = row_full(row_i);
    assign free_way = first_free(row_i);

    always_comb begin
        if (dup_i.hit)  way_o = dup_i.way;
        else if (!full) way_o = free_way;
        else            way_o = ptr_q[set_i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < TLB_SETS; s++) ptr_q[s] <= '0;
        end else if (fill_en_i && !dup_i.hit && full) begin
            ptr_q[set_i] <= ptr_q[set_i] + 1'b1;
        end
    end

    // R5
    victim_free_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_en_i && !dup_i.hit && !full) |-> !row_i[way_o].vld);

    // R7
    victim_dup_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_en_i && dup_i.hit) |-> (row_i[way_o].vld && row_i[way_o].ppn == dup_i.ppn));

endmodule

// File: rtl/tlb_top.sv
module tlb_top
    import tlb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  logic                 lkp_valid,
    input  logic [TLB_VA_W-1:0]  lkp_va,
    input  logic                 fill_valid,
    input  logic [TLB_VPN_W-1:0] fill_vpn,
    input  logic [TLB_PPN_W-1:0] fill_ppn,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic                 rsp_miss,
    output logic [TLB_PA_W-1:0]  rsp_pa
);

    vpn_t     lk_vpn;
    offset_t  lk_off;
    set_idx_t lk_set, fl_set;
    tag_t     lk_tag, fl_tag;

    assign lk_vpn = lkp_va[TLB_VA_W-1:TLB_OFF_W];
    assign lk_off = lkp_va[TLB_OFF_W-1:0];
    assign lk_set = set_of(lk_vpn);
    assign lk_tag = tag_of(lk_vpn);
    assign fl_set = set_of(fill_vpn);
    assign fl_tag = tag_of(fill_vpn);

    tlb_row_t row_lk, row_fl;
    logic     fill_en;
    way_idx_t wr_way;
    tlb_ent_t wr_ent;

    assign fill_en = fill_valid && !flush;
    assign wr_ent  = '{vld: 1'b1, tag: fl_tag, ppn: fill_ppn};

    tlb_store u_store (
        .clk      (clk),
        .rst      (rst),
        .flush_i  (flush),
        .we_i     (fill_en),
        .wset_i   (fl_set),
        .wway_i   (wr_way),
        .went_i   (wr_ent),
        .rset_a_i (lk_set),
        .rset_b_i (fl_set),
        .row_a_o  (row_lk),
        .row_b_o  (row_fl)
    );

    logic [TLB_WAYS-1:0] lk_vec, fl_vec;
    match_t              lk_res, fl_res;

    tlb_tag_match u_match_lk (
        .row_i     (row_lk),
        .tag_i     (lk_tag),
        .hit_vec_o (lk_vec),
        .res_o     (lk_res)
    );

    tlb_tag_match u_match_fl (
        .row_i     (row_fl),
        .tag_i     (fl_tag),
        .hit_vec_o (fl_vec),
        .res_o     (fl_res)
    );

    tlb_victim u_victim (
        .clk       (clk),
        .rst       (rst),
        .fill_en_i (fill_en),
        .set_i     (fl_set),
        .row_i     (row_fl),
        .dup_i     (fl_res),
        .way_o     (wr_way)
    );

    logic set_clash, hit_d;
    assign set_clash = fill_valid && (fl_set == lk_set);
    assign hit_d     = lkp_valid && lk_res.hit && !flush && !set_clash;

    logic                rsp_valid_q, rsp_hit_q;
    logic [TLB_PA_W-1:0] rsp_pa_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= 1'b0;
            rsp_hit_q   <= 1'b0;
            rsp_pa_q    <= '0;
        end else begin
            rsp_valid_q <= lkp_valid;
            rsp_hit_q   <= hit_d;
            rsp_pa_q    <= hit_d ? {lk_res.ppn, lk_off} : '0;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_hit   = rsp_hit_q;
    assign rsp_miss  = rsp_valid_q && !rsp_hit_q;
    assign rsp_pa    = rsp_pa_q;

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        lkp_valid |=> rsp_valid);

    // R2
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !lkp_valid |=> !(rsp_valid || rsp_hit || rsp_miss));

    // R2
    rsp_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_hit != rsp_miss));

    // R4
    pa_offset_chk: assert property (@(posedge clk) disable iff (rst)
        lkp_valid |=> (rsp_hit |-> (rsp_pa[TLB_OFF_W-1:0] == $past(lkp_va[TLB_OFF_W-1:0]))));

    // R4
    miss_pa_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> (rsp_pa == '0));

    // R8
    clash_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (lkp_valid && set_clash) |=> rsp_miss);

    // R9
    flush_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (lkp_valid && flush) |=> rsp_miss);

    // R7
    unique_tag_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_vec) && $onehot0(fl_vec));

endmodule

// File: tb/tb_tlb_top.sv
module tb_tlb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        flush;
    logic        lkp_valid;
    logic [31:0] lkp_va;
    logic        fill_valid;
    logic [19:0] fill_vpn;
    logic [19:0] fill_ppn;
    logic        rsp_valid, rsp_hit, rsp_miss;
    logic [31:0] rsp_pa;

    always #5 clk = ~clk;

    tlb_top dut (
        .clk(clk), .rst(rst), .flush(flush),
        .lkp_valid(lkp_valid), .lkp_va(lkp_va),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_pa(rsp_pa)
    );

    // behavioural model
    bit m_vld [16][4];
    int m_tag [16][4];
    int m_ppn [16][4];
    int m_ptr [16];

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int s = 0; s < 16; s++) begin
            m_ptr[s] = 0;
            for (int w = 0; w < 4; w++) begin
                m_vld[s][w] = 0; m_tag[s][w] = 0; m_ppn[s][w] = 0;
            end
        end
    endtask

    task automatic step(input string req, input bit lv, input logic [31:0] va,
                        input bit fv, input logic [19:0] fvpn, input logic [19:0] fppn, input bit fl);
        bit          exp_hit = 0;
        logic [31:0] exp_pa  = '0;
        int          s, t, w;
        lkp_valid = lv; lkp_va = va; fill_valid = fv; fill_vpn = fvpn; fill_ppn = fppn; flush = fl;
        s = int'(va[15:12]); t = int'(va[31:16]);
        if (lv && !fl && !(fv && fvpn[3:0] == va[15:12])) begin
            for (int i = 0; i < 4; i++) begin
                if (m_vld[s][i] && m_tag[s][i] == t) begin
                    exp_hit = 1;
                    exp_pa  = {m_ppn[s][i][19:0], va[11:0]};
                end
            end
        end
        if (fl) begin
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 4; b++) m_vld[a][b] = 0;
        end else if (fv) begin
            s = int'(fvpn[3:0]); t = int'(fvpn[19:4]); w = -1;
            for (int i = 0; i < 4; i++)
                if (w < 0 && m_vld[s][i] && m_tag[s][i] == t) w = i;
            for (int i = 0; i < 4; i++)
                if (w < 0 && !m_vld[s][i]) w = i;
            if (w < 0) begin
                w = m_ptr[s];
                m_ptr[s] = (m_ptr[s] + 1) % 4;
            end
            m_vld[s][w] = 1; m_tag[s][w] = t; m_ppn[s][w] = int'(fppn);
        end
        @(posedge clk); #2;
        check("R2", "rsp_valid", {31'b0, rsp_valid}, {31'b0, lv});
        check("R2", "rsp_miss",  {31'b0, rsp_miss},  {31'b0, lv && !exp_hit});
        check(req,  "rsp_hit",   {31'b0, rsp_hit},   {31'b0, exp_hit});
        check(req,  "rsp_pa",    rsp_pa, exp_pa);
    endtask

    task automatic lookup(input string req, input logic [19:0] vpn, input logic [11:0] off);
        step(req, 1, {vpn, off}, 0, '0, '0, 0);
    endtask

    task automatic refill(input string req, input logic [19:0] vpn, input logic [19:0] ppn);
        step(req, 0, '0, 1, vpn, ppn, 0);
    endtask

    function automatic logic [19:0] mk(input int tag, input int set);
        return {tag[15:0], set[3:0]};
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        model_clear();
        rst = 1; flush = 0; lkp_valid = 1; lkp_va = 32'h1234_5678;
        fill_valid = 0; fill_vpn = '0; fill_ppn = '0;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #2;
            check("R1", "rsp_valid in reset", {31'b0, rsp_valid}, 32'h0);
        end
        rst = 0;

        // R1: empty after reset
        for (int s = 0; s < 16; s++) lookup("R1", mk(16'h1234, s), 12'h678);
        step("R2", 0, '0, 0, '0, '0, 0);

        // R5 and R3: fill set 3 with four tags, all hit
        refill("R5", mk(16'hA000, 3), 20'h0AAAA);
        lookup("R5", mk(16'hA000, 3), 12'hFFF);
        refill("R5", mk(16'hB000, 3), 20'h0BBBB);
        refill("R5", mk(16'hC000, 3), 20'h0CCCC);
        refill("R5", mk(16'hD000, 3), 20'h0DDDD);
        lookup("R3", mk(16'hA000, 3), 12'h001);
        lookup("R4", mk(16'hB000, 3), 12'hABC);
        lookup("R3", mk(16'hC000, 3), 12'h800);
        lookup("R4", mk(16'hD000, 3), 12'h000);
        lookup("R3", mk(16'hA000, 4), 12'h123);   // same tag, other set
        lookup("R3", mk(16'hA001, 3), 12'h123);   // other tag, same set

        // R6: round robin eviction
        refill("R6", mk(16'hE000, 3), 20'h0EEEE);
        lookup("R6", mk(16'hA000, 3), 12'h010);
        lookup("R6", mk(16'hE000, 3), 12'h010);
        lookup("R6", mk(16'hB000, 3), 12'h010);
        refill("R6", mk(16'hF000, 3), 20'h0FFFF);
        lookup("R6", mk(16'hB000, 3), 12'h020);

        // R7: duplicate tag overwrites, no eviction, pointer kept
        refill("R7", mk(16'hC000, 3), 20'h12345);
        lookup("R7", mk(16'hC000, 3), 12'h5A5);
        lookup("R7", mk(16'hD000, 3), 12'h5A5);
        lookup("R7", mk(16'hE000, 3), 12'h5A5);
        refill("R7", mk(16'h7000, 3), 20'h77777);
        lookup("R7", mk(16'hC000, 3), 12'h001);
        lookup("R7", mk(16'hD000, 3), 12'h001);

        // R8: refill/lookup collisions
        step("R8", 1, {mk(16'hD000, 3), 12'h444}, 1, mk(16'h9000, 3), 20'h99999, 0);
        lookup("R8", mk(16'h9000, 3), 12'h444);
        step("R8", 1, {mk(16'h9000, 3), 12'h321}, 1, mk(16'h9000, 5), 20'h55555, 0);
        lookup("R8", mk(16'h9000, 5), 12'h321);

        // R9: flush
        step("R9", 1, {mk(16'h9000, 3), 12'h111}, 1, mk(16'h4444, 7), 20'h44444, 1);
        lookup("R9", mk(16'h9000, 3), 12'h111);
        lookup("R9", mk(16'h9000, 5), 12'h111);
        lookup("R9", mk(16'h4444, 7), 12'h111);
        for (int i = 0; i < 5; i++) refill("R9", mk(16'h2000 + i, 3), 20'h20000 + 20'(i));
        for (int i = 0; i < 5; i++) lookup("R9", mk(16'h2000 + i, 3), 12'h0F0);

        // R10: all 64 entries
        step("R9", 0, '0, 0, '0, '0, 1);
        for (int s = 0; s < 16; s++)
            for (int w = 0; w < 4; w++)
                refill("R10", mk(s * 7 + w + 100, s), 20'(s * 4 + w + 1));
        for (int s = 0; s < 16; s++)
            for (int w = 0; w < 4; w++)
                lookup("R10", mk(s * 7 + w + 100, s), 12'(s * 16 + w));

        // random stream against the model (all requirements)
        for (int i = 0; i < 3000; i++) begin
            bit          lv = 1'($urandom_range(0, 3) != 0);
            bit          fv = 1'($urandom_range(0, 2) == 0);
            bit          fl = 1'($urandom_range(0, 199) == 0);
            logic [19:0] lvpn = mk($urandom_range(0, 7), $urandom_range(0, 15));
            logic [19:0] fvpn = mk($urandom_range(0, 7), $urandom_range(0, 15));
            step("R6", lv, {lvpn, 12'($urandom)}, fv, fvpn, 20'($urandom), fl);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule